// File: doc/BRIEF.md
# Multiplexed Bus Address Splitter and Cycle Decoder

This block sits next to an 8-bit CPU whose low address byte and data byte share one set of pins. The CPU presents the low address byte on the shared lines only in the first state of a machine cycle, and marks that state with ALE. The block keeps that byte. It joins the kept byte with the upper byte from the dedicated high address lines and presents the result as one stable 16-bit address for the rest of the cycle.

The block also turns the CPU's two status pins, its IO/M select and its active-low read, write and interrupt-acknowledge strobes into a set of one-hot cycle flags. The flags are halt, opcode fetch, memory read, memory write, I/O read, I/O write and interrupt acknowledge. The status and IO/M values are captured together with the address. The flags therefore keep the cycle type from the start of the cycle until the next ALE, even if the status pins move in between.

Top module: `addr_cycle_decoder`

## Requirements
- R1: `addrOut[15:8]` always equals `addrHi`.
- R2: While `ale` is 1, `addrOut[7:0]` follows `adBus` without waiting for a clock edge.
- R3: When `ale` is 0, `addrOut[7:0]` holds the `adBus` value sampled at the last rising clock edge at which `ale` was 1. Later changes on `adBus` do not affect it.
- R4: A status of S1,S0 = 0,0 sets only `cycleFlags[0]` (halt). This does not depend on `rdN`, `wrN` or `intaN`.
- R5: A status of 1,1 with `rdN`=0, `ioM`=0 and `intaN`=1 sets only `cycleFlags[1]` (opcode fetch).
- R6: A status of 1,0 with `rdN`=0 and `intaN`=1 sets `cycleFlags[2]` (memory read) when `ioM`=0, and `cycleFlags[4]` (I/O read) when `ioM`=1.
- R7: A status of 0,1 with `wrN`=0 and `intaN`=1 sets `cycleFlags[3]` (memory write) when `ioM`=0, and `cycleFlags[5]` (I/O write) when `ioM`=1.
- R8: When the status is not halt, `intaN`=0 sets only `cycleFlags[6]` (interrupt acknowledge). This takes precedence over any read or write decode.
- R9: Outside a halt, all flags are 0 in two cases: when `rdN`, `wrN` and `intaN` are all 1, and when the asserted strobe does not match the status (for example a read strobe on a write status).
- R10: The status pins and `ioM` are decoded live while `ale` is 1 and captured at each rising clock edge at which `ale` is 1. While `ale` is 0, the flags use the captured values, and changes on those pins have no effect.
- R11: After reset, and until the first ALE, `addrOut[7:0]` is 0 and all flags are 0.
- R12: At most one flag is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address-latch strobe from the CPU, active high |
| adBus | input | 8 | Shared low-address/data lines |
| addrHi | input | 8 | Dedicated upper address lines |
| statusS1 | input | 1 | Status pin S1 |
| statusS0 | input | 1 | Status pin S0 |
| ioM | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| intaN | input | 1 | Interrupt-acknowledge strobe, active low |
| addrOut | output | 16 | Demultiplexed address |
| cycleFlags | output | 7 | One-hot flags: [6] int ack, [5] I/O write, [4] I/O read, [3] mem write, [2] mem read, [1] fetch, [0] halt |

## Verification
The assertions assume that `ale` is high for at least one rising clock edge in each machine cycle. They also assume that the status pins and `ioM` are valid at that edge, as the CPU guarantees. The stimulus raises `ale` for exactly one clock per cycle, with status, IO/M and the address already set. It changes inputs only 1 ns after a rising edge and drops the strobes before the next ALE. The "held" checks also assume that `adBus` carries data rather than address after `ale` falls. The bench drives a different data byte at that point so that a leak would show.

// File: rtl/addr_cycle_pkg.sv
package addr_cycle_pkg;
  localparam int FLAG_W = 7;

  typedef enum logic [2:0] {
    F_HALT   = 3'd0,
    F_FETCH  = 3'd1,
    F_MEMRD  = 3'd2,
    F_MEMWR  = 3'd3,
    F_IORD   = 3'd4,
    F_IOWR   = 3'd5,
    F_INTACK = 3'd6
  } flagIdx_e;

  typedef struct packed {
    logic captureAddr;
    logic passLive;
  } pathStrobe_t;
endpackage

// File: rtl/addr_cycle_ctrl.sv
module addr_cycle_ctrl
  import addr_cycle_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ale,
  input  logic              statusS1,
  input  logic              statusS0,
  input  logic              ioM,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              intaN,
  output pathStrobe_t       strobe,
  output logic [FLAG_W-1:0] flags
);
  logic [1:0] heldStatus;
  logic       heldIoM;
  logic       heldValid;
  logic [1:0] curStatus;
  logic       curIoM;
  logic       curValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldStatus <= 2'b00;
      heldIoM    <= 1'b0;
      heldValid  <= 1'b0;
    end else if (ale) begin
      heldStatus <= {statusS1, statusS0};
      heldIoM    <= ioM;
      heldValid  <= 1'b1;
    end
  end

  always_comb begin
    strobe.captureAddr = ale;
    strobe.passLive    = ale;
    curStatus = ale ? {statusS1, statusS0} : heldStatus;
    curIoM    = ale ? ioM : heldIoM;
    curValid  = ale | heldValid;
  end

  always_comb begin
    flags = '0;
    if (curValid) begin
      if (curStatus == 2'b00) begin
        flags[F_HALT] = 1'b1;
      end else if (!intaN) begin
        flags[F_INTACK] = 1'b1;
      end else begin
        unique case (curStatus)
          2'b11: if (!rdN && !curIoM) flags[F_FETCH] = 1'b1;
          2'b10: if (!rdN) begin
                   if (curIoM) flags[F_IORD] = 1'b1;
                   else        flags[F_MEMRD] = 1'b1;
                 end
          2'b01: if (!wrN) begin
                   if (curIoM) flags[F_IOWR] = 1'b1;
                   else        flags[F_MEMWR] = 1'b1;
                 end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/addr_cycle_path.sv
module addr_cycle_path
  import addr_cycle_pkg::*;
#(
  parameter int HI_W = 8,
  parameter int LO_W = 8,
  localparam int ADDR_W = HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathStrobe_t       strobe,
  input  logic [LO_W-1:0]   adBus,
  input  logic [HI_W-1:0]   addrHi,
  output logic [ADDR_W-1:0] addrOut
);
  logic [LO_W-1:0] lowHeld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   lowHeld <= '0;
    else if (strobe.captureAddr) lowHeld <= adBus;
  end

  assign addrOut = {addrHi, strobe.passLive ? adBus : lowHeld};
endmodule

// File: rtl/addr_cycle_decoder.sv
module addr_cycle_decoder
  import addr_cycle_pkg::*;
#(
  parameter int HI_W = 8,
  parameter int LO_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ale,
  input  logic [LO_W-1:0]      adBus,
  input  logic [HI_W-1:0]      addrHi,
  input  logic                 statusS1,
  input  logic                 statusS0,
  input  logic                 ioM,
  input  logic                 rdN,
  input  logic                 wrN,
  input  logic                 intaN,
  output logic [HI_W+LO_W-1:0] addrOut,
  output logic [FLAG_W-1:0]    cycleFlags
);
  pathStrobe_t strobe;

  addr_cycle_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .ale(ale),
    .statusS1(statusS1), .statusS0(statusS0), .ioM(ioM),
    .rdN(rdN), .wrN(wrN), .intaN(intaN),
    .strobe(strobe), .flags(cycleFlags)
  );

  addr_cycle_path #(.HI_W(HI_W), .LO_W(LO_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .adBus(adBus), .addrHi(addrHi), .addrOut(addrOut)
  );
endmodule

// File: rtl/addr_cycle_chk.sv
module addr_cycle_chk
  import addr_cycle_pkg::*;
#(
  parameter int HI_W = 8,
  parameter int LO_W = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 ale,
  input logic [LO_W-1:0]      adBus,
  input logic [HI_W-1:0]      addrHi,
  input logic                 statusS1,
  input logic                 statusS0,
  input logic                 rdN,
  input logic                 wrN,
  input logic                 intaN,
  input logic [HI_W+LO_W-1:0] addrOut,
  input logic [FLAG_W-1:0]    cycleFlags
);
  assert_flags_onehot_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cycleFlags));

  assert_high_byte_R1: assert property (@(posedge clk) disable iff (!rstN)
    addrOut[HI_W+LO_W-1:LO_W] == addrHi);

  assert_low_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> addrOut[LO_W-1:0] == adBus);

  assert_low_captured_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ale && $past(ale)) |-> addrOut[LO_W-1:0] == $past(adBus));

  assert_low_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ale && !$past(ale)) |-> $stable(addrOut[LO_W-1:0]));

  assert_halt_live_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ale && !statusS1 && !statusS0) |-> cycleFlags[F_HALT]);

  assert_intack_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!intaN && !cycleFlags[F_HALT] && (ale || $past(ale) || $past(cycleFlags) != '0 || cycleFlags != '0))
      |-> cycleFlags[F_INTACK] || (cycleFlags == '0 && !ale));

  assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdN && wrN && intaN && !cycleFlags[F_HALT]) |-> cycleFlags == '0);

  assert_halt_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!ale && !$past(ale)) |-> $stable(cycleFlags[F_HALT]));
endmodule

bind addr_cycle_decoder addr_cycle_chk #(.HI_W(HI_W), .LO_W(LO_W)) uChk (
  .clk(clk), .rstN(rstN), .ale(ale), .adBus(adBus), .addrHi(addrHi),
  .statusS1(statusS1), .statusS0(statusS0), .rdN(rdN), .wrN(wrN),
  .intaN(intaN), .addrOut(addrOut), .cycleFlags(cycleFlags)
);

// File: tb/addr_cycle_decoder_test.sv
module addr_cycle_decoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ale = 1'b0;
  logic [7:0]  adBus = 8'h00;
  logic [7:0]  addrHi = 8'h00;
  logic        statusS1 = 1'b0, statusS0 = 1'b0, ioM = 1'b0;
  logic        rdN = 1'b1, wrN = 1'b1, intaN = 1'b1;
  logic [15:0] addrOut;
  logic [6:0]  cycleFlags;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  addr_cycle_decoder uut (
    .clk(clk), .rstN(rstN), .ale(ale), .adBus(adBus), .addrHi(addrHi),
    .statusS1(statusS1), .statusS0(statusS0), .ioM(ioM),
    .rdN(rdN), .wrN(wrN), .intaN(intaN),
    .addrOut(addrOut), .cycleFlags(cycleFlags)
  );

  // Vector fields: {s1, s0, ioM, rdN, wrN, intaN, expected flags[6:0]}
  // Flag bits: 6 intAck, 5 ioWr, 4 ioRd, 3 memWr, 2 memRd, 1 fetch, 0 halt
  localparam int NVEC = 13;
  localparam logic [12:0] VEC [NVEC] = '{
    {2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 7'b0000001},  // R4 halt
    {2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 7'b0000001},  // R4 halt ignores rd
    {2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 7'b0000010},  // R5 fetch
    {2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 7'b0000100},  // R6 mem read
    {2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 7'b0010000},  // R6 io read
    {2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 7'b0001000},  // R7 mem write
    {2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 7'b0100000},  // R7 io write
    {2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 7'b1000000},  // R8 int ack
    {2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 7'b1000000},  // R8 precedence
    {2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 7'b0000000},  // R9 idle
    {2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 7'b0000000},  // R9 rd on write status
    {2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 7'b0000000},  // R9 wr on fetch status
    {2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 7'b0000001}   // R4 halt ignores inta
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // One machine cycle: ALE for one clock with status and address, then strobes
  task automatic runCycle(input logic [12:0] v, input logic [7:0] lo, input logic [7:0] hi);
    rdN = 1'b1; wrN = 1'b1; intaN = 1'b1;
    ale = 1'b1; adBus = lo; addrHi = hi;
    {statusS1, statusS0, ioM} = v[12:10];
    step();
    ale = 1'b0; adBus = ~lo;
    {rdN, wrN, intaN} = v[9:7];
    #1;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rdN = 1'b0; wrN = 1'b0;
    step(); step();
    rdN = 1'b1; wrN = 1'b1;
    rstN = 1'b1; addrHi = 8'h3C; adBus = 8'h99;
    step();
    check("R11 low addr after reset", {8'h00, addrOut[7:0]}, 16'h0000);
    check("R11 flags after reset", {9'h0, cycleFlags}, 16'h0000);
    rdN = 1'b0; #1;
    check("R11 flags before first ALE with rd", {9'h0, cycleFlags}, 16'h0000);
    rdN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      runCycle(VEC[i], 8'h10 + 8'(i), 8'hA0 + 8'(i));
      check($sformatf("R4-R9 vector %0d flags", i), {9'h0, cycleFlags}, {9'h0, VEC[i][6:0]});
      check($sformatf("R3 vector %0d address", i), addrOut, {8'hA0 + 8'(i), 8'h10 + 8'(i)});
    end

    // R2: transparent low byte while ALE high
    rdN = 1'b1; wrN = 1'b1; intaN = 1'b1;
    ale = 1'b1; adBus = 8'h55; addrHi = 8'h12;
    {statusS1, statusS0, ioM} = 3'b100;
    #1;
    check("R2 follows adBus", addrOut, 16'h1255);
    adBus = 8'h66; #1;
    check("R2 follows adBus change", addrOut, 16'h1266);
    step();
    ale = 1'b0; adBus = 8'h77; #1;
    check("R3 holds captured byte", addrOut, 16'h1266);
    step(); step();
    check("R3 holds across clocks", addrOut, 16'h1266);
    addrHi = 8'hF0; #1;
    check("R1 high byte passes through", addrOut, 16'hF066);

    // R10: status pin changes after ALE are ignored
    rdN = 1'b0;
    {statusS1, statusS0, ioM} = 3'b001;
    step(); step();
    check("R10 captured mem read kept", {9'h0, cycleFlags}, 16'h0004);
    {statusS1, statusS0} = 2'b00; #1;
    check("R10 live halt status ignored", {9'h0, cycleFlags}, 16'h0004);
    rdN = 1'b1; #1;
    check("R9 strobe release clears", {9'h0, cycleFlags}, 16'h0000);

    // R10: live decode during ALE, I/O write captured then pins moved
    ale = 1'b1; {statusS1, statusS0, ioM} = 3'b011; adBus = 8'h21;
    step();
    ale = 1'b0; {statusS1, statusS0, ioM} = 3'b110; wrN = 1'b0;
    step();
    check("R10 captured io write kept", {9'h0, cycleFlags}, 16'h0020);
    check("R12 single flag", {15'h0, ($countones(cycleFlags) <= 1)}, 16'h0001);

    // R11: reset mid-cycle clears captured state
    rstN = 1'b0; #1;
    rstN = 1'b1; #1;
    check("R11 flags after mid-cycle reset", {9'h0, cycleFlags}, 16'h0000);
    check("R11 low addr after mid-cycle reset", {8'h00, addrOut[7:0]}, 16'h0000);
    wrN = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule